// File: doc/BRIEF.md
# Interrupt Aggregation and NMI Routing Unit

This block gathers interrupt request lines from the on-chip peripherals and turns them into 32 processor interrupt lines. Each line has up to three sub-source inputs. Every sub-source passes through a two-flop synchronizer into the processor clock domain. An interrupt line is high when any of its valid synchronized sub-sources is high, or when software has raised that line through the control word. A 5-bit selector picks one of the 32 lines and sends it to the non-maskable interrupt output.

Software reaches the block through a simple word-addressed register port. The port offers one read-only identify word per line, showing which sub-sources are active. It also offers the selector word and the control word. Writing a 1 to a control bit toggles the software contribution of that line, based on the line's state at that moment: an idle line gets raised, and an asserted line gets its software contribution removed. This lets test software inject or clear any interrupt without involving the peripherals.

Top module: `irq_aggr_unit`

## Requirements
- R1: After synchronous reset, `irq_o` and `nmi_o` are 0, and reads of the selector word (0x80) and the control word (0x84) return 0.
- R2: A sub-source change sampled at clock edge k shows on `irq_o` just after edge k+1 and not earlier. Line n is the OR of its valid synchronized sub-sources and its software bit.
- R3: The identify word at byte offset 4·n (n = 0..31) returns line n's synchronized sub-source flags in bits [2:0], with the upper bits 0. Line 4 has sub-sources in bits 0 and 1. Line 5 has sub-sources in bits 0, 1 and 2. Every other non-reserved line has only bit 0. Sub-source inputs outside these positions read as 0 and never drive the line.
- R4: Lines 21, 22 and 30 are reserved. Their sub-source inputs are ignored, their identify words read 0, and hardware never drives them.
- R5: A write to 0x80 loads `reg_wdata[4:0]` into the selector. A read returns the selector zero-extended. `nmi_o` equals `irq_o[selector]` without delay.
- R6: Writing 1 to bit n of 0x84 while `irq_o[n]` is 0 sets the software bit of line n, so `irq_o[n]` is 1 from the next cycle.
- R7: Writing 1 to bit n of 0x84 while `irq_o[n]` is 1 clears the software bit of line n. The line stays high only while a hardware sub-source is still active.
- R8: Bits written as 0 to 0x84 leave their software bits unchanged.
- R9: A read of 0x84 returns the state of all 32 interrupt lines in the cycle of the read.
- R10: Writes to the identify words and to offsets above 0x84 change nothing. Reads above 0x84 return 0. Address bits [1:0] are ignored.
- R11: `reg_rdata` is registered. It takes the addressed value at the edge where `reg_rd_en` is high and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 96 | Peripheral sub-sources, line n at bits [3n+2:3n] |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 32 | Interrupt lines toward the processor |
| nmi_o | output | 1 | Non-maskable interrupt output |

## Verification
Each result has a fixed latency, and the bench samples it on the falling edge of that exact cycle. A sub-source change is driven on a falling edge and checked twice: still low after one rising edge, then high after the second. A register write changes `irq_o`, `nmi_o` and the selector after one rising edge. Read data is checked one rising edge after the read strobe. The bench also checks that read data stays the same while later writes change the lines.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    localparam int unsigned LINES      = 32;
    localparam int unsigned FLAG_W     = 3;
    localparam int unsigned BUS_AW     = 8;
    localparam int unsigned BUS_DW     = 32;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        WIN_IDENT = 2'd0,
        WIN_NMI   = 2'd1,
        WIN_CTL   = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    // Which sub-source positions exist on a given line.
    function automatic logic [FLAG_W-1:0] live_flags(input int unsigned line);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (line)
            21, 22, 30: m = '0;
            4:          m[1:0] = 2'b11;
            5:          m = '1;
            default:    m[0] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

    // R2: the first stage captures the raw input every cycle
    a_r2_first_capture: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stg[0] == $past(din)));

endmodule

// File: rtl/irqa_swreg.sv
module irqa_swreg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] line,
    output logic [WIDTH-1:0] sw_q
);

    logic [WIDTH-1:0] sw_d;

    always_comb begin
        sw_d = sw_q;
        if (wr_stb) sw_d = (sw_q & ~wdata) | (wdata & ~line);
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= '0;
        else     sw_q <= sw_d;
    end

    a_r6_set_idle: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> ((sw_q & $past(wdata & ~line)) == $past(wdata & ~line)));

    a_r7_clear_busy: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> ((sw_q & $past(wdata & line)) == '0));

    a_r8_zero_bits: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (((sw_q ^ $past(sw_q)) & ~$past(wdata)) == '0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(sw_q));

endmodule

// File: rtl/irqa_regif.sv
module irqa_regif
    import irqa_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SEL_W   = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [SEL_W-1:0]               sel_wdata,
    input  logic [NUM_IRQ-1:0][SRC_W-1:0]  flags,
    input  logic [NUM_IRQ-1:0]             line,
    output logic [DATA_W-1:0]              rdata,
    output logic                           ctl_wr,
    output logic [SEL_W-1:0]               nmi_sel
);

    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ);
    localparam logic [WIDX_W-1:0] NMI_WORD = WIDX_W'(NUM_IRQ);
    localparam logic [WIDX_W-1:0] CTL_WORD = WIDX_W'(NUM_IRQ + 1);

    logic [WIDX_W-1:0] word_idx;
    logic [IDX_W-1:0]  ident_idx;
    logic              addr_unused;
    win_e              win;
    logic [DATA_W-1:0] rd_next;

    assign word_idx    = addr[ADDR_W-1:2];
    assign ident_idx   = word_idx[IDX_W-1:0];
    assign addr_unused = ^addr[1:0];

    always_comb begin
        if (word_idx < NMI_WORD)       win = WIN_IDENT;
        else if (word_idx == NMI_WORD) win = WIN_NMI;
        else if (word_idx == CTL_WORD) win = WIN_CTL;
        else                           win = WIN_NONE;
    end

    always_comb begin
        rd_next = '0;
        case (win)
            WIN_IDENT: rd_next[SRC_W-1:0]   = flags[ident_idx];
            WIN_NMI:   rd_next[SEL_W-1:0]   = nmi_sel;
            WIN_CTL:   rd_next[NUM_IRQ-1:0] = line;
            default:   rd_next = '0;
        endcase
    end

    assign ctl_wr = wr_en && (win == WIN_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_sel <= '0;
            rdata   <= '0;
        end else begin
            if (wr_en && (win == WIN_NMI)) nmi_sel <= sel_wdata;
            if (rd_en)                     rdata   <= rd_next;
        end
    end

    a_r5_sel_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && win == WIN_NMI) |=> (nmi_sel == $past(sel_wdata)));

    a_r9_line_readback: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win == WIN_CTL) |=> (rdata[NUM_IRQ-1:0] == $past(line)));

    a_r10_beyond_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win == WIN_NONE) |=> (rdata == '0));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/irq_aggr_unit.sv
module irq_aggr_unit
    import irqa_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = LINES,
    parameter int unsigned SRC_W       = FLAG_W,
    parameter int unsigned ADDR_W      = BUS_AW,
    parameter int unsigned DATA_W      = BUS_DW,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IRQ*SRC_W-1:0]   src_i,
    input  logic                       reg_wr_en,
    input  logic                       reg_rd_en,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_IRQ-1:0]         irq_o,
    output logic                       nmi_o
);

    localparam int unsigned SEL_W = $clog2(NUM_IRQ);
    localparam int unsigned FLAT  = NUM_IRQ * SRC_W;

    logic [FLAT-1:0]                src_live;
    logic [FLAT-1:0]                src_sync;
    logic [NUM_IRQ-1:0][SRC_W-1:0]  flags;
    logic [NUM_IRQ-1:0]             hw_line;
    logic [NUM_IRQ-1:0]             sw_q;
    logic [NUM_IRQ-1:0]             line;
    logic                           ctl_wr;
    logic [SEL_W-1:0]               nmi_sel;

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
        localparam logic [SRC_W-1:0] LIVE = SRC_W'(live_flags(n));
        assign src_live[n*SRC_W +: SRC_W] = src_i[n*SRC_W +: SRC_W] & LIVE;
        assign flags[n]   = src_sync[n*SRC_W +: SRC_W];
        assign hw_line[n] = |flags[n];
    end

    irqa_sync #(
        .WIDTH  (FLAT),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src_live),
        .dout (src_sync)
    );

    irqa_swreg #(
        .WIDTH (NUM_IRQ)
    ) i_swreg (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (ctl_wr),
        .wdata  (reg_wdata[NUM_IRQ-1:0]),
        .line   (line),
        .sw_q   (sw_q)
    );

    irqa_regif #(
        .NUM_IRQ (NUM_IRQ),
        .SRC_W   (SRC_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) i_regif (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .sel_wdata (reg_wdata[SEL_W-1:0]),
        .flags     (flags),
        .line      (line),
        .rdata     (reg_rdata),
        .ctl_wr    (ctl_wr),
        .nmi_sel   (nmi_sel)
    );

    assign line  = hw_line | sw_q;
    assign irq_o = line;
    assign nmi_o = line[nmi_sel];

    // R4: hardware never drives a reserved line
    a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (flags[21] == '0 && flags[22] == '0 && flags[30] == '0));

endmodule

// File: tb/test_irq_aggr_unit.sv
module test_irq_aggr_unit;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] src_i = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_o;
    logic        nmi_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggr_unit i_irq_aggr_unit (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        tick();
        reg_rd_en = 1'b0;
    endtask

    task automatic set_src(input int line, input logic [2:0] v);
        src_i[line*3 +: 3] = v;
    endtask

    task automatic t_reset();
        check("R1 irq_o", irq_o, 32'h0);
        check("R1 nmi_o", {31'b0, nmi_o}, 32'h0);
        reg_read(8'h84);
        check("R1 ctl word", reg_rdata, 32'h0);
        reg_read(8'h80);
        check("R1 sel word", reg_rdata, 32'h0);
    endtask

    task automatic t_latency();
        set_src(8, 3'b001);
        tick();
        check("R2 one edge", irq_o, 32'h0);
        tick();
        check("R2 two edges", irq_o, 32'h0000_0100);
        reg_read(8'h20);
        check("R3 ident line8", reg_rdata, 32'h1);
        set_src(8, 3'b000);
        tick();
        check("R2 fall one edge", irq_o, 32'h0000_0100);
        tick();
        check("R2 fall two edges", irq_o, 32'h0);
    endtask

    task automatic t_merge();
        set_src(5, 3'b101);
        set_src(4, 3'b110);
        set_src(9, 3'b110);
        tick(); tick();
        check("R3 merged lines", irq_o, 32'h0000_0030);
        reg_read(8'h14);
        check("R3 ident line5", reg_rdata, 32'h5);
        reg_read(8'h10);
        check("R3 ident line4", reg_rdata, 32'h2);
        reg_read(8'h27);
        check("R3 ident line9 masked", reg_rdata, 32'h0);
        set_src(5, 3'b000); set_src(4, 3'b000); set_src(9, 3'b000);
        tick(); tick();
        check("R2 merged clear", irq_o, 32'h0);
    endtask

    task automatic t_reserved();
        set_src(21, 3'b111); set_src(22, 3'b111); set_src(30, 3'b111);
        tick(); tick(); tick();
        check("R4 reserved lines", irq_o, 32'h0);
        reg_read(8'h54);
        check("R4 ident 21", reg_rdata, 32'h0);
        reg_read(8'h58);
        check("R4 ident 22", reg_rdata, 32'h0);
        reg_read(8'h78);
        check("R4 ident 30", reg_rdata, 32'h0);
        src_i = '0;
        tick(); tick();
    endtask

    task automatic t_soft();
        reg_write(8'h84, 32'h0002_0008);
        check("R6 raise", irq_o, 32'h0002_0008);
        reg_read(8'h84);
        check("R9 readback", reg_rdata, 32'h0002_0008);
        reg_write(8'h84, 32'h0);
        check("R8 zero write", irq_o, 32'h0002_0008);
        reg_write(8'h84, 32'h0000_0008);
        check("R7 clear one", irq_o, 32'h0002_0000);
        set_src(8, 3'b001);
        tick(); tick();
        reg_read(8'h84);
        check("R9 readback hw", reg_rdata, 32'h0002_0100);
        reg_write(8'h84, 32'h0000_0100);
        check("R7 hw still high", irq_o, 32'h0002_0100);
        set_src(8, 3'b000);
        tick(); tick();
        check("R7 sw not set", irq_o, 32'h0002_0000);
        reg_write(8'h84, 32'h0002_0000);
        check("R7 clear rest", irq_o, 32'h0);
    endtask

    task automatic t_nmi();
        reg_write(8'h80, 32'h0000_002A);
        reg_read(8'h80);
        check("R5 sel readback", reg_rdata, 32'h0000_000A);
        check("R5 nmi idle", {31'b0, nmi_o}, 32'h0);
        reg_write(8'h84, 32'h0000_0400);
        check("R5 nmi routed", {31'b0, nmi_o}, 32'h1);
        reg_write(8'h80, 32'h0000_0000);
        check("R5 nmi reselect", {31'b0, nmi_o}, 32'h0);
        reg_write(8'h80, 32'h0000_000A);
        reg_write(8'h84, 32'h0000_0400);
        check("R5 nmi follows clear", {31'b0, nmi_o}, 32'h0);
    endtask

    task automatic t_ignored();
        reg_write(8'h20, 32'hFFFF_FFFF);
        reg_write(8'h90, 32'hFFFF_FFFF);
        reg_write(8'hFC, 32'hFFFF_FFFF);
        check("R10 ro write lines", irq_o, 32'h0);
        reg_read(8'h20);
        check("R10 ro write ident", reg_rdata, 32'h0);
        reg_read(8'h80);
        check("R10 sel untouched", reg_rdata, 32'h0000_000A);
        reg_write(8'h84, 32'h1);
        reg_read(8'h88);
        check("R10 read 0x88", reg_rdata, 32'h0);
        reg_read(8'hFC);
        check("R10 read 0xFC", reg_rdata, 32'h0);
        reg_write(8'h84, 32'h1);
    endtask

    task automatic t_hold();
        reg_write(8'h84, 32'h0000_0002);
        reg_read(8'h84);
        check("R11 read value", reg_rdata, 32'h0000_0002);
        reg_write(8'h84, 32'h0000_0004);
        check("R11 lines moved", irq_o, 32'h0000_0006);
        check("R11 rdata held", reg_rdata, 32'h0000_0002);
        reg_write(8'h84, 32'h0000_0006);
        check("R11 cleanup", irq_o, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_merge();
        t_reserved();
        t_soft();
        t_nmi();
        t_ignored();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule